// File: doc/BRIEF.md
# Vector SHA-2 Instruction Legality Checker

This block decides, with no clock and no stored state, whether a vector SHA-2 hash instruction may issue. It takes the selected element width, the destination and two source register indices, the start index, the vector length, the register-group multiplier and two enable bits, one for the 32-bit-word hash family and one for the 64-bit-word family. It returns a legal flag and, when the instruction is rejected, a one-hot code naming the rule that failed.

The rules are checked in two tiers. The first tier holds the rules that apply to every width: the element width itself and the overlap between registers. The second tier holds the rules that depend on the width: the extension enable and whether an element group fits in the register group. The alignment of the start index and the vector length to the element group of four is checked last. The issue stage uses `legal` to let the instruction through, and it passes `reason` to its trap logic.

Top module: `vsha_legality_check`

## Requirements
- R1: The element-width code `sewSel` must be 2 (32-bit) or 3 (64-bit). Any other code makes the instruction illegal with `reason` = 5'b00001.
- R2: If the width is valid and `vd` equals `vs1`, the instruction is illegal with `reason` = 5'b00010.
- R3: If the width is valid and `vd` equals `vs2`, the instruction is illegal with `reason` = 5'b00010.
- R4: With 32-bit width, `en256` must be 1. Otherwise, once the common tier passes, `reason` = 5'b00100. The value of `en512` has no effect at this width.
- R5: With 64-bit width, `en512` must be 1. Otherwise, once the common tier passes, `reason` = 5'b00100. The value of `en256` has no effect at this width.
- R6: The register group holds VLEN×LMUL bits. `lmulSel` codes 0..3 mean LMUL 1, 2, 4, 8, codes 5, 6, 7 mean 1/8, 1/4, 1/2, and code 4 means a group of 0 bits. The group must hold 128 bits at 32-bit width and 256 bits at 64-bit width. A group that is too small gives `reason` = 5'b01000.
- R7: `vstart` and `vl` must both be multiples of 4. Otherwise `reason` = 5'b10000.
- R8: When several rules fail, `reason` reports only the first one in the order width, overlap, extension, group fit, alignment. `reason` never has more than one bit set.
- R9: `legal` is 1 exactly when every rule passes, and `reason` is then 5'b00000.
- R10: Both outputs are pure combinational functions of the current inputs, so they are valid in the same cycle the inputs are applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sewSel | input | 3 | Element-width code (2 = 32-bit, 3 = 64-bit, others rejected) |
| vd | input | 5 | Destination register index |
| vs1 | input | 5 | First source register index |
| vs2 | input | 5 | Second source register index |
| vstart | input | LEN_W | Start element index |
| vl | input | LEN_W | Vector length in elements |
| lmulSel | input | 3 | Register-group multiplier code |
| en256 | input | 1 | 32-bit-word hash family enabled |
| en512 | input | 1 | 64-bit-word hash family enabled |
| legal | output | 1 | Instruction may execute |
| reason | output | 5 | One-hot code of the first failing rule, zero when legal |

## Verification
There is no register between the inputs and the outputs, so every result is due in the same cycle its inputs are applied, after zero clock edges. The bench changes the inputs on the falling clock edge and samples `legal` and `reason` a quarter period later, before the next rising edge, so each sample belongs to exactly one input set. The main sweep covers every width code, every multiplier code, all four enable combinations, three overlap patterns and four alignment patterns. Directed cases then cover the remaining corners.

// File: rtl/vsha_legal_pkg.sv
package vsha_legal_pkg;

  // One-hot rejection codes; bit order is the report priority (low first)
  typedef enum logic [4:0] {
    RSN_NONE    = 5'b00000,
    RSN_WIDTH   = 5'b00001,
    RSN_OVERLAP = 5'b00010,
    RSN_EXT     = 5'b00100,
    RSN_FIT     = 5'b01000,
    RSN_ALIGN   = 5'b10000
  } reason_e;

  // Raw rule strobes from the evaluator to the priority control
  typedef struct packed {
    logic widthBad;
    logic overlapBad;
    logic extBad;
    logic fitBad;
    logic alignBad;
  } fault_t;

  localparam logic [2:0] SEW_CODE_32 = 3'd2;
  localparam logic [2:0] SEW_CODE_64 = 3'd3;

  // Register-group size in bits for a multiplier code; code 4 is reserved
  function automatic int unsigned groupBitsOf(input int unsigned vlenBits,
                                              input logic [2:0] code);
    int unsigned bits;
    case (code)
      3'd0, 3'd1, 3'd2, 3'd3: bits = vlenBits << code;
      3'd5, 3'd6, 3'd7:       bits = vlenBits >> (4'd8 - {1'b0, code});
      default:                bits = 0;
    endcase
    return bits;
  endfunction

endpackage

// File: rtl/vsha_rule_eval.sv
module vsha_rule_eval
  import vsha_legal_pkg::*;
#(
  parameter int unsigned VLEN  = 128,
  parameter int unsigned LEN_W = 16,
  parameter int unsigned EGS   = 4,
  parameter int unsigned REG_W = 5
) (
  input  logic [2:0]       sewSel,
  input  logic [REG_W-1:0] vd,
  input  logic [REG_W-1:0] vs1,
  input  logic [REG_W-1:0] vs2,
  input  logic [LEN_W-1:0] vstart,
  input  logic [LEN_W-1:0] vl,
  input  logic [2:0]       lmulSel,
  input  logic             en256,
  input  logic             en512,
  output fault_t           faults
);

  localparam int unsigned EGW32 = EGS * 32;
  localparam int unsigned EGW64 = EGS * 64;

  logic        is32;
  logic        is64;
  int unsigned groupBits;
  int unsigned needBits;

  assign is32 = (sewSel == SEW_CODE_32);
  assign is64 = (sewSel == SEW_CODE_64);

  always_comb begin
    groupBits = groupBitsOf(VLEN, lmulSel);
    needBits  = is64 ? EGW64 : EGW32;

    faults.widthBad   = !(is32 || is64);
    faults.overlapBad = (vd == vs1) || (vd == vs2);
    faults.extBad     = (is32 && !en256) || (is64 && !en512);
    faults.fitBad     = (is32 || is64) && (groupBits < needBits);
    faults.alignBad   = ((vstart % LEN_W'(EGS)) != '0) ||
                        ((vl % LEN_W'(EGS)) != '0);
  end

endmodule

// File: rtl/vsha_priority_ctl.sv
module vsha_priority_ctl
  import vsha_legal_pkg::*;
(
  input  fault_t      faults,
  output logic        legal,
  output logic [4:0]  reason
);

  logic    commonOk;
  logic    widthTierOk;
  reason_e pick;

  // Tier one: rules shared by both widths
  assign commonOk    = !faults.widthBad && !faults.overlapBad;
  // Tier two: width-specific rules, consulted only when tier one passes
  assign widthTierOk = !faults.extBad && !faults.fitBad;

  always_comb begin
    pick = RSN_NONE;
    if (faults.widthBad)        pick = RSN_WIDTH;
    else if (faults.overlapBad) pick = RSN_OVERLAP;
    else if (faults.extBad)     pick = RSN_EXT;
    else if (faults.fitBad)     pick = RSN_FIT;
    else if (faults.alignBad)   pick = RSN_ALIGN;
  end

  assign reason = pick;
  assign legal  = commonOk && widthTierOk && !faults.alignBad;

endmodule

// File: rtl/vsha_legality_check.sv
module vsha_legality_check
  import vsha_legal_pkg::*;
#(
  parameter int unsigned VLEN  = 128,
  parameter int unsigned LEN_W = 16,
  parameter int unsigned EGS   = 4
) (
  input  logic [2:0]       sewSel,
  input  logic [4:0]       vd,
  input  logic [4:0]       vs1,
  input  logic [4:0]       vs2,
  input  logic [LEN_W-1:0] vstart,
  input  logic [LEN_W-1:0] vl,
  input  logic [2:0]       lmulSel,
  input  logic             en256,
  input  logic             en512,
  output logic             legal,
  output logic [4:0]       reason
);

  fault_t faults;

  vsha_rule_eval #(
    .VLEN (VLEN),
    .LEN_W(LEN_W),
    .EGS  (EGS),
    .REG_W(5)
  ) u_eval (
    .sewSel (sewSel),
    .vd     (vd),
    .vs1    (vs1),
    .vs2    (vs2),
    .vstart (vstart),
    .vl     (vl),
    .lmulSel(lmulSel),
    .en256  (en256),
    .en512  (en512),
    .faults (faults)
  );

  vsha_priority_ctl u_ctl (
    .faults(faults),
    .legal (legal),
    .reason(reason)
  );

endmodule

// File: rtl/vsha_legality_sva.sv
module vsha_legality_sva #(
  parameter int unsigned LEN_W = 16
) (
  input logic [2:0]       sewSel,
  input logic [4:0]       vd,
  input logic [4:0]       vs1,
  input logic [4:0]       vs2,
  input logic [LEN_W-1:0] vstart,
  input logic [LEN_W-1:0] vl,
  input logic [2:0]       lmulSel,
  input logic             en256,
  input logic             en512,
  input logic             legal,
  input logic [4:0]       reason
);

  logic widthOk;
  assign widthOk = (sewSel == 3'd2) || (sewSel == 3'd3);

  always_comb begin
    a_r8_reason_onehot: assert ($onehot0(reason))
      else $error("R8: reason %05b has several bits", reason);
    a_r9_legal_no_reason: assert (legal == (reason == 5'b00000))
      else $error("R9: legal %0b with reason %05b", legal, reason);
    a_r1_width_first: assert (widthOk || (reason == 5'b00001))
      else $error("R1: bad width %0d gave reason %05b", sewSel, reason);
    a_r2_no_dst_src1: assert (!legal || (vd != vs1))
      else $error("R2: legal with vd == vs1");
    a_r3_no_dst_src2: assert (!legal || (vd != vs2))
      else $error("R3: legal with vd == vs2");
    a_r4_ext32: assert (!(legal && sewSel == 3'd2) || en256)
      else $error("R4: legal 32-bit width with en256 low");
    a_r5_ext64: assert (!(legal && sewSel == 3'd3) || en512)
      else $error("R5: legal 64-bit width with en512 low");
    a_r6_reserved_group: assert (!legal || (lmulSel != 3'd4))
      else $error("R6: legal with reserved multiplier code");
    a_r7_aligned: assert (!legal || ((vstart[1:0] == 2'b00) && (vl[1:0] == 2'b00)))
      else $error("R7: legal with misaligned start %0d or length %0d", vstart, vl);
  end

endmodule

bind vsha_legality_check vsha_legality_sva #(.LEN_W(LEN_W)) u_sva (
  .sewSel (sewSel),
  .vd     (vd),
  .vs1    (vs1),
  .vs2    (vs2),
  .vstart (vstart),
  .vl     (vl),
  .lmulSel(lmulSel),
  .en256  (en256),
  .en512  (en512),
  .legal  (legal),
  .reason (reason)
);

// File: tb/vsha_legality_check_test.sv
`timescale 1ns/1ps
module vsha_legality_check_test;

  localparam int unsigned LEN_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;   // 50 MHz

  logic [2:0]       sewSel = '0;
  logic [4:0]       vd = '0, vs1 = '0, vs2 = '0;
  logic [LEN_W-1:0] vstart = '0, vl = '0;
  logic [2:0]       lmulSel = '0;
  logic             en256 = 1'b0, en512 = 1'b0;
  logic             legal;
  logic [4:0]       reason;

  int numRun  = 0;
  int numFail = 0;
  bit done    = 0;

  vsha_legality_check #(.VLEN(128), .LEN_W(LEN_W), .EGS(4)) uut (
    .sewSel(sewSel), .vd(vd), .vs1(vs1), .vs2(vs2),
    .vstart(vstart), .vl(vl), .lmulSel(lmulSel),
    .en256(en256), .en512(en512), .legal(legal), .reason(reason)
  );

  // Reference model taken from the requirements, VLEN = 128
  function automatic logic [4:0] expectReason(
      input logic [2:0] s, input logic [4:0] d, input logic [4:0] a,
      input logic [4:0] b, input logic [LEN_W-1:0] st, input logic [LEN_W-1:0] n,
      input logic [2:0] m, input logic e2, input logic e5);
    int grp;
    int need;
    case (m)
      3'd0: grp = 128;  3'd1: grp = 256;  3'd2: grp = 512; 3'd3: grp = 1024;
      3'd5: grp = 16;   3'd6: grp = 32;   3'd7: grp = 64;  default: grp = 0;
    endcase
    need = (s == 3'd3) ? 256 : 128;
    if (s != 3'd2 && s != 3'd3)            return 5'b00001;  // R1
    if (d == a || d == b)                  return 5'b00010;  // R2 R3
    if ((s == 3'd2 && !e2) || (s == 3'd3 && !e5)) return 5'b00100;  // R4 R5
    if (grp < need)                        return 5'b01000;  // R6
    if ((st % 4) != 0 || (n % 4) != 0)     return 5'b10000;  // R7
    return 5'b00000;                                          // R9
  endfunction

  task automatic apply(input logic [2:0] s, input logic [4:0] d, input logic [4:0] a,
                       input logic [4:0] b, input logic [LEN_W-1:0] st,
                       input logic [LEN_W-1:0] n, input logic [2:0] m,
                       input logic e2, input logic e5);
    @(negedge clk);
    sewSel = s; vd = d; vs1 = a; vs2 = b; vstart = st; vl = n;
    lmulSel = m; en256 = e2; en512 = e5;
    #5;   // outputs due in the same cycle (R10)
  endtask

  task automatic check(input string tag, input logic expL, input logic [4:0] expR);
    numRun++;
    if (legal !== expL || reason !== expR) begin
      numFail++;
      $display("FAIL %s: legal=%0b reason=%05b expected legal=%0b reason=%05b",
               tag, legal, reason, expL, expR);
    end
  endtask

  task automatic checkModel(input string tag);
    logic [4:0] r;
    r = expectReason(sewSel, vd, vs1, vs2, vstart, vl, lmulSel, en256, en512);
    check(tag, r == 5'b00000, r);
  endtask

  function automatic string tagOf(input logic [4:0] r);
    case (r)
      5'b00001: return "R1 sweep";
      5'b00010: return "R2 R3 sweep";
      5'b00100: return "R4 R5 sweep";
      5'b01000: return "R6 sweep";
      5'b10000: return "R7 sweep";
      default:  return "R9 sweep";
    endcase
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk); #5;
    check("R1 idle inputs after reset", 1'b0, 5'b00001);

    // Main sweep
    for (int s = 0; s < 8; s++)
      for (int m = 0; m < 8; m++)
        for (int e = 0; e < 4; e++)
          for (int ov = 0; ov < 3; ov++)
            for (int al = 0; al < 4; al++) begin
              logic [LEN_W-1:0] st;
              logic [LEN_W-1:0] n;
              st = LEN_W'(8 * s) + ((al == 1 || al == 3) ? LEN_W'(2) : LEN_W'(0));
              n  = LEN_W'(64 + 4 * m) + ((al == 2 || al == 3) ? LEN_W'(3) : LEN_W'(0));
              apply(3'(s), 5'd8, (ov == 1) ? 5'd8 : 5'd2, (ov == 2) ? 5'd8 : 5'd4,
                    st, n, 3'(m), e[0], e[1]);
              checkModel(tagOf(expectReason(3'(s), 5'd8, (ov == 1) ? 5'd8 : 5'd2,
                         (ov == 2) ? 5'd8 : 5'd4, st, n, 3'(m), e[0], e[1])));
            end

    // Directed corners
    apply(3'd2, 5'd1, 5'd2, 5'd3, 16'd0, 16'd0, 3'd0, 1'b1, 1'b0);
    check("R9 minimal legal 32-bit, en512 ignored (R4)", 1'b1, 5'b00000);
    apply(3'd2, 5'd1, 5'd2, 5'd3, 16'd0, 16'd4, 3'd0, 1'b0, 1'b1);
    check("R4 en512 alone does not enable 32-bit", 1'b0, 5'b00100);
    apply(3'd3, 5'd1, 5'd2, 5'd3, 16'd4, 16'd8, 3'd1, 1'b1, 1'b0);
    check("R5 en256 alone does not enable 64-bit", 1'b0, 5'b00100);
    apply(3'd3, 5'd1, 5'd2, 5'd3, 16'd4, 16'd8, 3'd1, 1'b0, 1'b1);
    check("R5 legal 64-bit at LMUL 2, en256 ignored", 1'b1, 5'b00000);
    apply(3'd3, 5'd1, 5'd2, 5'd3, 16'd4, 16'd8, 3'd0, 1'b1, 1'b1);
    check("R6 64-bit group does not fit LMUL 1", 1'b0, 5'b01000);
    apply(3'd2, 5'd1, 5'd2, 5'd3, 16'd4, 16'd8, 3'd7, 1'b1, 1'b1);
    check("R6 32-bit group does not fit LMUL 1/2", 1'b0, 5'b01000);
    apply(3'd2, 5'd1, 5'd2, 5'd3, 16'd4, 16'd8, 3'd4, 1'b1, 1'b1);
    check("R6 reserved multiplier code", 1'b0, 5'b01000);
    apply(3'd2, 5'd9, 5'd9, 5'd9, 16'd0, 16'd8, 3'd0, 1'b1, 1'b1);
    check("R2 R3 all three indices equal", 1'b0, 5'b00010);
    apply(3'd2, 5'd31, 5'd0, 5'd31, 16'd0, 16'd8, 3'd0, 1'b1, 1'b1);
    check("R3 destination equals second source only", 1'b0, 5'b00010);
    apply(3'd2, 5'd31, 5'd31, 5'd0, 16'd0, 16'd8, 3'd0, 1'b1, 1'b1);
    check("R2 destination equals first source only", 1'b0, 5'b00010);
    apply(3'd3, 5'd1, 5'd2, 5'd3, 16'hFFFC, 16'hFFFF, 3'd3, 1'b0, 1'b1);
    check("R7 top-of-range length misaligned", 1'b0, 5'b10000);
    apply(3'd3, 5'd1, 5'd2, 5'd3, 16'hFFFC, 16'hFFFC, 3'd3, 1'b0, 1'b1);
    check("R7 top-of-range aligned is legal", 1'b1, 5'b00000);
    apply(3'd7, 5'd4, 5'd4, 5'd4, 16'd1, 16'd1, 3'd4, 1'b0, 1'b0);
    check("R8 all rules fail, width reported", 1'b0, 5'b00001);
    apply(3'd3, 5'd4, 5'd4, 5'd5, 16'd1, 16'd1, 3'd4, 1'b0, 1'b0);
    check("R8 overlap outranks extension, fit, alignment", 1'b0, 5'b00010);
    apply(3'd3, 5'd4, 5'd6, 5'd5, 16'd1, 16'd1, 3'd4, 1'b0, 1'b0);
    check("R8 extension outranks fit and alignment", 1'b0, 5'b00100);
    apply(3'd3, 5'd4, 5'd6, 5'd5, 16'd1, 16'd1, 3'd4, 1'b0, 1'b1);
    check("R8 fit outranks alignment", 1'b0, 5'b01000);

    // R10: change inputs inside one cycle, result follows without a clock edge
    @(negedge clk);
    sewSel = 3'd2; vd = 5'd1; vs1 = 5'd2; vs2 = 5'd3; vstart = '0; vl = 16'd4;
    lmulSel = 3'd0; en256 = 1'b1; en512 = 1'b0;
    #2; check("R10 same-cycle legal", 1'b1, 5'b00000);
    vl = 16'd5;
    #2; check("R10 same-cycle misalign", 1'b0, 5'b10000);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", numRun, numFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      numRun++;
      numFail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", numRun, numFail);
      $finish;
    end
  end

endmodule